// File: doc/BRIEF.md
# Scanline Playfield Pixel Generator

The block draws the coarse background layer of a low-resolution raster video generator. Each scanline is 228 color-clock ticks long. The first 68 ticks are horizontal blanking, and the remaining 160 ticks are visible. Three shadow registers of 4, 8 and 8 bits hold the playfield bits. Each bit covers four color clocks, so one half of the visible line holds 20 coarse pixels. The right half either repeats the left half or draws it mirrored, depending on a mode input.

A processor writes the registers through a select/data/strobe port. A write does not reach the picture at once. It waits in a short pipeline and lands either 2 color clocks later (the normal setting) or 3 color clocks later (the slow setting). One processor cycle equals three color clocks, so these delays are two-thirds of a cycle and one full cycle. Software that rewrites registers while the beam crosses the line depends on this exact timing. A line-start pulse puts the horizontal counter back to the start of blanking.

All state advances only on clock edges where the color-clock enable is high. The outputs are registered, and each one describes the position that was current at the last tick.

Top module: `pf_scan_gen`

## Requirements
- R1: After each tick, `hpos_o` reports the position that was current before the tick. The position runs 0 to 227 and then wraps to 0. Without a tick the position and all outputs hold.
- R2: `hblank_o` is 1 exactly when `hpos_o` is below 68, and `pix_o` is 0 whenever `hblank_o` is 1.
- R3: For `hpos_o` from 68 to 147, the coarse index is i = (hpos_o-68)/4. Index 0..3 draws register 0 bit 4+i. Index 4..11 draws register 1 bit 11-i. Index 12..19 draws register 2 bit i-12. Select code 0 writes register 0, which keeps data bits 7..4. Code 1 writes register 1 and code 2 writes register 2.
- R4: With `mirror_mode` at 0, `hpos_o` from 148 to 227 uses the same mapping as R3 with i = (hpos_o-148)/4.
- R5: With `mirror_mode` at 1, `hpos_o` from 148 to 227 uses the R3 mapping with i = 19-(hpos_o-148)/4.
- R6: With `lat_slow` at 0, take a write strobed on a tick that reports `hpos_o` = h. The first position drawn with the new value is h+2; positions h and h+1 still show the old value.
- R7: With `lat_slow` at 1, the first position drawn with the new value is h+3; positions h, h+1 and h+2 still show the old value.
- R8: In mirror mode, a register 2 write timed to land at position 148 leaves position 147 (the left copy) unchanged and changes position 148 (the mirrored copy). This holds under both latency settings.
- R9: A strobe on a clock edge without a tick has no effect. A write with select code 3 changes no register.
- R10: A line-start pulse makes the next tick report position 0. A write still pending when the pulse arrives is not lost.
- R11: Synchronous reset clears all three registers and drops pending writes. It sets `hpos_o` to 0, `hblank_o` to 1 and `pix_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cc_tick | input | 1 | Color-clock enable; one tick per color clock |
| line_start | input | 1 | Restarts the horizontal count at the start of blanking |
| wr_en | input | 1 | Write strobe, sampled on ticks |
| wr_sel | input | 2 | Register select: 0, 1, 2; 3 selects nothing |
| wr_data | input | 8 | Write data |
| lat_slow | input | 1 | 0: write visible after 2 ticks; 1: after 3 ticks |
| mirror_mode | input | 1 | 0: right half repeats left; 1: right half mirrored |
| pix_o | output | 1 | Playfield pixel for the reported position |
| hblank_o | output | 1 | High during horizontal blanking |
| hpos_o | output | 8 | Reported horizontal position, 0 to 227 |

## Verification
Two actions can meet on the same tick: a delayed write maturing into a shadow register, and that same register being read for the pixel being drawn. The bench provokes this in mirror mode by timing a register 2 write to land exactly between the left copy and the mirrored copy, once per latency setting. It also times writes into the middle of a coarse pixel. The pixel on each side of the landing tick is checked: the earlier position must keep the old bit and the later one must take the new bit. A separate case overlaps a pending write with a line-start pulse and checks that the write still arrives.

// File: rtl/pfgen_pkg.sv
package pfgen_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 2;
  localparam int R0_PIX = 4;
  localparam int R1_PIX = 8;
  localparam int R2_PIX = 8;
  localparam int HALF_PIX = R0_PIX + R1_PIX + R2_PIX;

  typedef enum logic [SEL_W-1:0] {
    SEL_R0   = 2'd0,
    SEL_R1   = 2'd1,
    SEL_R2   = 2'd2,
    SEL_NONE = 2'd3
  } pf_sel_e;

  typedef struct packed {
    logic              vld;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] data;
  } pf_wr_t;
endpackage

// File: rtl/pf_hcounter.sv
module pf_hcounter #(
  parameter int LINE_CLKS = 228,
  parameter int POS_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             line_start,
  output logic [POS_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || line_start) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == POS_W'(LINE_CLKS - 1)) cnt <= '0;
      else                             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pf_write_pipe.sv
module pf_write_pipe
  import pfgen_pkg::*;
#(
  parameter int FAST_DLY = 2,
  parameter int SLOW_DLY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              slow,
  output pf_wr_t            mature
);
  localparam int DEPTH    = SLOW_DLY - 1;
  localparam int TAP_FAST = FAST_DLY - 2;
  localparam int TAP_SLOW = SLOW_DLY - 2;

  pf_wr_t stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
    end else if (tick) begin
      stg[0] <= '{vld: wr_en, sel: wr_sel, data: wr_data};
      for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
    end
  end

  generate
    if (TAP_FAST == TAP_SLOW) begin : g_single_tap
      assign mature = stg[TAP_SLOW];
    end else begin : g_dual_tap
      assign mature = slow ? stg[TAP_SLOW] : stg[TAP_FAST];
    end
  endgenerate
endmodule

// File: rtl/pf_shadow_regs.sv
module pf_shadow_regs
  import pfgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  pf_wr_t            mature,
  output logic [R0_PIX-1:0] sh0,
  output logic [R1_PIX-1:0] sh1,
  output logic [R2_PIX-1:0] sh2
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sh0 <= '0;
      sh1 <= '0;
      sh2 <= '0;
    end else if (tick && mature.vld) begin
      case (pf_sel_e'(mature.sel))
        SEL_R0:  sh0 <= mature.data[DATA_W-1 -: R0_PIX];
        SEL_R1:  sh1 <= mature.data;
        SEL_R2:  sh2 <= mature.data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pf_pixel_map.sv
module pf_pixel_map
  import pfgen_pkg::*;
#(
  parameter int HBLANK_CLKS = 68,
  parameter int PIX_CLKS    = 4,
  parameter int POS_W       = 8
) (
  input  logic [POS_W-1:0]  cnt,
  input  logic              mirror,
  input  logic [R0_PIX-1:0] sh0,
  input  logic [R1_PIX-1:0] sh1,
  input  logic [R2_PIX-1:0] sh2,
  output logic              blank,
  output logic              pix
);
  localparam int HALF_CLKS = HALF_PIX * PIX_CLKS;
  localparam int IDX_W     = $clog2(HALF_PIX);
  localparam int R0_IW     = $clog2(R0_PIX);
  localparam int R1_IW     = $clog2(R1_PIX);
  localparam int R2_IW     = $clog2(R2_PIX);

  logic [POS_W-1:0] vis, off;
  logic             right;
  logic [IDX_W-1:0] idx_raw, idx;
  logic [R1_IW-1:0] b1;
  logic [R2_IW-1:0] b2;

  always_comb begin
    blank   = cnt < POS_W'(HBLANK_CLKS);
    vis     = cnt - POS_W'(HBLANK_CLKS);
    right   = vis >= POS_W'(HALF_CLKS);
    off     = right ? vis - POS_W'(HALF_CLKS) : vis;
    idx_raw = IDX_W'(off / POS_W'(PIX_CLKS));
    idx     = (right && mirror) ? IDX_W'(HALF_PIX - 1) - idx_raw : idx_raw;
    // register 1 is drawn high bit first, register 2 low bit first
    b1 = R1_IW'(IDX_W'(R0_PIX + R1_PIX - 1) - idx);
    b2 = R2_IW'(idx - IDX_W'(R0_PIX + R1_PIX));
    if (idx < IDX_W'(R0_PIX))                pix = sh0[idx[R0_IW-1:0]];
    else if (idx < IDX_W'(R0_PIX + R1_PIX))  pix = sh1[b1];
    else                                     pix = sh2[b2];
  end
endmodule

// File: rtl/pf_scan_gen.sv
module pf_scan_gen
  import pfgen_pkg::*;
#(
  parameter int LINE_CLKS   = 228,
  parameter int HBLANK_CLKS = 68,
  parameter int PIX_CLKS    = 4,
  parameter int FAST_DLY    = 2,
  parameter int SLOW_DLY    = 3,
  localparam int POS_W      = $clog2(LINE_CLKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cc_tick,
  input  logic              line_start,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lat_slow,
  input  logic              mirror_mode,
  output logic              pix_o,
  output logic              hblank_o,
  output logic [POS_W-1:0]  hpos_o
);
  logic [POS_W-1:0]  hcnt;
  pf_wr_t            mature;
  logic [R0_PIX-1:0] sh0;
  logic [R1_PIX-1:0] sh1;
  logic [R2_PIX-1:0] sh2;
  logic              blank_c, pix_c;

  pf_hcounter #(.LINE_CLKS(LINE_CLKS), .POS_W(POS_W)) u_hcnt (
    .clk(clk), .rst(rst), .tick(cc_tick), .line_start(line_start), .cnt(hcnt)
  );

  pf_write_pipe #(.FAST_DLY(FAST_DLY), .SLOW_DLY(SLOW_DLY)) u_wpipe (
    .clk(clk), .rst(rst), .tick(cc_tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .slow(lat_slow), .mature(mature)
  );

  pf_shadow_regs u_shadow (
    .clk(clk), .rst(rst), .tick(cc_tick), .mature(mature),
    .sh0(sh0), .sh1(sh1), .sh2(sh2)
  );

  pf_pixel_map #(.HBLANK_CLKS(HBLANK_CLKS), .PIX_CLKS(PIX_CLKS), .POS_W(POS_W)) u_map (
    .cnt(hcnt), .mirror(mirror_mode), .sh0(sh0), .sh1(sh1), .sh2(sh2),
    .blank(blank_c), .pix(pix_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hpos_o   <= '0;
      hblank_o <= 1'b1;
      pix_o    <= 1'b0;
    end else if (cc_tick) begin
      hpos_o   <= hcnt;
      hblank_o <= blank_c;
      pix_o    <= pix_c & ~blank_c;
    end
  end
endmodule

// File: rtl/pf_scan_gen_chk.sv
module pf_scan_gen_chk #(
  parameter int LINE_CLKS   = 228,
  parameter int HBLANK_CLKS = 68,
  parameter int POS_W       = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cc_tick,
  input logic             line_start,
  input logic             pix_o,
  input logic             hblank_o,
  input logic [POS_W-1:0] hpos_o,
  input logic [POS_W-1:0] cnt,
  input logic [3:0]       sh0,
  input logic [7:0]       sh1,
  input logic [7:0]       sh2
);
  AST_POS_BOUND: assert property (@(posedge clk) disable iff (rst)
    hpos_o < POS_W'(LINE_CLKS)); // R1
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cc_tick |=> $stable(hpos_o)); // R1
  AST_BLANK_FLAG: assert property (@(posedge clk) disable iff (rst)
    hblank_o == (hpos_o < POS_W'(HBLANK_CLKS))); // R2
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
    hblank_o |-> !pix_o); // R2
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cc_tick |=> $stable({sh0, sh1, sh2})); // R9
  AST_LINE_ZERO: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (cnt == '0)); // R10
endmodule

bind pf_scan_gen pf_scan_gen_chk #(
  .LINE_CLKS(LINE_CLKS), .HBLANK_CLKS(HBLANK_CLKS), .POS_W(POS_W)
) u_chk (
  .clk(clk), .rst(rst), .cc_tick(cc_tick), .line_start(line_start),
  .pix_o(pix_o), .hblank_o(hblank_o), .hpos_o(hpos_o), .cnt(hcnt),
  .sh0(sh0), .sh1(sh1), .sh2(sh2)
);

// File: tb/pf_scan_gen_test.sv
module pf_scan_gen_test;
  logic       clk = 1'b0, rst = 1'b1, cc_tick = 1'b0, line_start = 1'b0;
  logic       wr_en = 1'b0, lat_slow = 1'b0, mirror_mode = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       pix_o, hblank_o;
  logic [7:0] hpos_o;

  int n_run = 0, n_fail = 0, bpos = 0, last = -1, cyc = 0;
  logic [7:0] ra = '0, rb = '0, rc = '0;

  always #10 clk = ~clk;

  pf_scan_gen uut (
    .clk(clk), .rst(rst), .cc_tick(cc_tick), .line_start(line_start),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .lat_slow(lat_slow),
    .mirror_mode(mirror_mode), .pix_o(pix_o), .hblank_o(hblank_o), .hpos_o(hpos_o)
  );

  // mirror, visible position, expected pixel; registers 0x50 / 0x81 / 0x03
  localparam logic [9:0] VEC [18] = '{
    {1'b0, 8'd0, 1'b1},   {1'b0, 8'd3, 1'b1},   {1'b0, 8'd4, 1'b0},
    {1'b0, 8'd16, 1'b1},  {1'b0, 8'd20, 1'b0},  {1'b0, 8'd44, 1'b1},
    {1'b0, 8'd48, 1'b1},  {1'b0, 8'd56, 1'b0},  {1'b0, 8'd80, 1'b1},
    {1'b0, 8'd128, 1'b1}, {1'b1, 8'd80, 1'b0},  {1'b1, 8'd100, 1'b0},
    {1'b1, 8'd104, 1'b1}, {1'b1, 8'd108, 1'b1}, {1'b1, 8'd112, 1'b1},
    {1'b1, 8'd148, 1'b1}, {1'b1, 8'd156, 1'b1}, {1'b1, 8'd152, 1'b0}
  };

  function automatic bit ref_pix(int p, bit mir, logic [7:0] a, logic [7:0] b, logic [7:0] c);
    int v, i;
    if (p < 68) return 1'b0;
    v = p - 68;
    i = (v % 80) / 4;
    if (v >= 80 && mir) i = 19 - i;
    if (i < 4) return a[4+i];
    if (i < 12) return b[11-i];
    return c[i-12];
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick_w(bit we, logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    cc_tick = 1'b1; wr_en = we; wr_sel = s; wr_data = d;
    @(negedge clk);
    cc_tick = 1'b0; wr_en = 1'b0;
    last = bpos;
    bpos = (bpos + 1) % 228;
  endtask

  task automatic tick1();
    tick_w(1'b0, 2'd0, 8'h00);
  endtask

  task automatic restart();
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    bpos = 0; last = -1;
  endtask

  task automatic run_to(int t);
    while (last != t) tick1();
  endtask

  task automatic load(logic [1:0] s, logic [7:0] d);
    tick_w(1'b1, s, d);
    repeat (3) tick1();
    case (s)
      2'd0: ra = d;
      2'd1: rb = d;
      2'd2: rc = d;
      default: ;
    endcase
  endtask

  task automatic sweep(string tag);
    restart();
    for (int p = 0; p < 228; p++) begin
      tick1();
      chk({tag, " R1 hpos"}, hpos_o, p);
      chk({tag, " R2 hblank"}, hblank_o, (p < 68) ? 1 : 0);
      chk({tag, " pix"}, pix_o, ref_pix(p, mirror_mode, ra, rb, rc));
    end
  endtask

  task automatic lat_case(bit slow);
    lat_slow = slow; mirror_mode = 1'b0;
    load(2'd0, 8'h00); ra = '0;
    restart();
    run_to(67);
    tick_w(1'b1, 2'd0, 8'hF0);
    chk(slow ? "R7 write tick" : "R6 write tick", pix_o, 0);
    tick1(); chk(slow ? "R7 h+1" : "R6 h+1", pix_o, 0);
    tick1(); chk(slow ? "R7 h+2" : "R6 h+2", pix_o, slow ? 0 : 1);
    tick1(); chk(slow ? "R7 h+3" : "R6 h+3", pix_o, 1);
    ra = 8'hF0;
  endtask

  task automatic mid_case(bit slow);
    lat_slow = slow; mirror_mode = 1'b1;
    load(2'd2, 8'h00);
    restart();
    run_to(slow ? 144 : 145);
    tick_w(1'b1, 2'd2, 8'hFF);
    if (slow) begin tick1(); chk("R8 slow pos 146", pix_o, 0); end
    tick1(); chk(slow ? "R8 slow left copy 147" : "R8 fast left copy 147", pix_o, 0);
    tick1(); chk(slow ? "R8 slow mirror copy 148" : "R8 fast mirror copy 148", pix_o, 1);
    rc = 8'hFF;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R11 reset pix", pix_o, 0);
    chk("R11 reset hblank", hblank_o, 1);
    chk("R11 reset hpos", hpos_o, 0);

    // vector table: bit order and half-line mapping
    load(2'd0, 8'h50); load(2'd1, 8'h81); load(2'd2, 8'h03);
    foreach (VEC[n]) begin
      mirror_mode = VEC[n][9];
      restart();
      run_to(68 + int'(VEC[n][8:1]));
      chk(VEC[n][9] ? "R5 table" : (VEC[n][8:1] < 80 ? "R3 table" : "R4 table"),
          pix_o, VEC[n][0]);
    end

    // full lines, both modes
    load(2'd0, 8'hA5); load(2'd1, 8'h3C); load(2'd2, 8'h96);
    mirror_mode = 1'b0; sweep("R3 R4 repeat line");
    mirror_mode = 1'b1; sweep("R5 mirror line");
    load(2'd0, 8'hFF); load(2'd1, 8'hFF); load(2'd2, 8'hFF);
    mirror_mode = 1'b0; sweep("R2 all-ones line");

    // latency boundaries
    lat_case(1'b0);
    lat_case(1'b1);
    mid_case(1'b0);
    mid_case(1'b1);

    // ignored writes
    lat_slow = 1'b0; mirror_mode = 1'b0;
    load(2'd0, 8'h00); load(2'd1, 8'h00); load(2'd2, 8'h00);
    @(negedge clk); wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'hFF;
    @(negedge clk); wr_en = 1'b0;
    load(2'd3, 8'hFF);
    sweep("R9 ignored writes");

    // pending write survives a line restart
    lat_slow = 1'b1;
    restart();
    run_to(100);
    tick_w(1'b1, 2'd0, 8'hF0);
    restart();
    tick1();
    chk("R10 first tick after restart", hpos_o, 0);
    run_to(68);
    chk("R10 pending write kept", pix_o, 1);
    ra = 8'hF0;

    // reset in mid-run
    load(2'd1, 8'hFF); load(2'd2, 8'hFF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    ra = '0; rb = '0; rc = '0; bpos = 0; last = -1;
    chk("R11 mid reset hpos", hpos_o, 0);
    chk("R11 mid reset hblank", hblank_o, 1);
    sweep("R11 cleared registers");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule